// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block is a small register-mapped responder that plays the sink side of an auxiliary-channel request carrying I2C traffic. The host sees one control register and five data registers. It places a request header in the first data register and then writes the control register with the send-busy bit set. Within the same clock edge the block decodes the header and updates its I2C session: start or restart, stop, and whether the display-data target is selected. It then overwrites control with a completion word and the first data register with the reply.

The data bytes come from a local 128-byte display identification table, which is filled through a dedicated load port. Address-only messages (length 3) are the I2C start, restart and stop events. Read messages (length 4) return one table byte and advance a pointer. Write messages are acknowledged and have no other effect. There is no physical signalling and no wait time: every request completes at once.

Top module: `aux_i2c_edid_resp`

## Requirements
- R1: After reset all six registers read zero, the session holds no selected target, and the byte pointer is 0.
- R2: The low address byte decodes the registers: 0x10 is control, and 0x14, 0x18, 0x1C, 0x20 and 0x24 are data 1 to 5. Host writes to the data registers are stored and read back unchanged. Any other offset reads zero, and writes to it are dropped.
- R3: A control write with bit 31 (send-busy) clear changes no register and no session state.
- R4: A control write with bit 31 set replaces control with bit 30 (done) set and the reply size in bits 24:20. The reply size is 2 when header bit 28 is set (read) and 1 otherwise. All other control bits, including bit 31, are 0.
- R5: The request header is taken from data 1. The operation nibble is bits 31:28, bit 28 is the read flag and bit 30 is the middle-of-transaction (MOT) flag. The I2C address is bits 23:8. The message length is bits 24:20 of the control value being written, as a plain binary count.
- R6: A length-3 message with MOT clear acts as a stop. It deselects the target, clears the display-data-available flag and returns the pointer to 0.
- R7: A length-3 message with MOT set and address 0 resets the session in the same way. With MOT set and address 0x0050, it selects the target and sets the available flag if monitor_present_i is high. Once set, the flag stays set until a session reset.
- R8: A length-4 read while the target is selected and available writes data 1 as {ACK 0x00, table[pointer], 16'h0000} and then increments the pointer.
- R9: A length-4 read while the target is not selected or not available returns 0xFF in data 1 bits 23:16 with ACK in bits 31:24, and leaves the pointer unchanged.
- R10: A length-4 read with the pointer at 128 returns byte 0x00 and leaves the pointer unchanged.
- R11: A write request of any length other than 3 sets data 1 to {ACK 0x00, 24'h0} and leaves the session unchanged.
- R12: A read request with a length other than 3 or 4 updates control as in R4 and leaves data 1 unchanged.
- R13: A table load with tbl_we_i high writes tbl_data_i at tbl_addr_i. Later reads return that byte at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write offset (low address byte) |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 8 | Register read offset |
| rd_data_o | output | 32 | Register read data (combinational) |
| monitor_present_i | input | 1 | A display is attached on this port |
| tbl_we_i | input | 1 | Table load strobe |
| tbl_addr_i | input | 7 | Table load index |
| tbl_data_i | input | 8 | Table load byte |

## Verification
Directed sequences cover each session path in turn. A read before any selection must give 0xFF. A select followed by reads must walk the table bytes in order. A write request placed between reads tells whether the session was wrongly disturbed, because the next read must continue from the same byte. A stop, an address-0 restart and a select with no monitor must each return the block to the 0xFF answer. Reading to the end of the table and beyond separates the pointer limit from wraparound. A seeded random mix of headers, lengths, address values, monitor levels and plain data writes is compared against a bench model after every access, to catch wrong field positions and wrong priorities.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_D1   = 3'd1,
    SEL_D2   = 3'd2,
    SEL_D3   = 3'd3,
    SEL_D4   = 3'd4,
    SEL_D5   = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned N_DATA   = 5;
  localparam int unsigned BUSY_BIT = 31;
  localparam int unsigned DONE_BIT = 30;
  localparam int unsigned SIZE_LSB = 20;
  localparam int unsigned SIZE_W   = 5;
  localparam int unsigned OP_READ_BIT = 0;
  localparam int unsigned OP_MOT_BIT  = 2;

  localparam logic [SIZE_W-1:0] ADDR_ONLY_LEN = 5'd3;
  localparam logic [SIZE_W-1:0] READ_LEN      = 5'd4;
  localparam logic [SIZE_W-1:0] RSZ_READ      = 5'd2;
  localparam logic [SIZE_W-1:0] RSZ_WRITE     = 5'd1;
  localparam logic [7:0]        ACK_CODE      = 8'h00;
  localparam logic [7:0]        MISS_BYTE     = 8'hFF;

  typedef struct packed {
    logic [3:0]        op;
    logic [15:0]       addr;
    logic [SIZE_W-1:0] len;
  } req_hdr_t;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    case (off)
      8'h10:   return SEL_CTRL;
      8'h14:   return SEL_D1;
      8'h18:   return SEL_D2;
      8'h1C:   return SEL_D3;
      8'h20:   return SEL_D4;
      8'h24:   return SEL_D5;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/edid_table.sv
module edid_table #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/aux_i2c_session.sv
module aux_i2c_session
  import aux_edid_pkg::*;
#(
  parameter int unsigned DEPTH       = 128,
  parameter logic [15:0] TARGET_ADDR = 16'h0050,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  req_hdr_t          hdr_i,
  input  logic              monitor_i,
  input  logic [7:0]        tbl_byte_i,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output logic              d1_wr_o,
  output logic [DATA_W-1:0] d1_val_o
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             sel_q, sel_n;
  logic             avail_q, avail_n;
  logic [7:0]       byte_c;

  always_comb begin
    sel_n    = sel_q;
    avail_n  = avail_q;
    ptr_n    = ptr_q;
    d1_wr_o  = 1'b0;
    byte_c   = 8'h00;
    d1_val_o = '0;
    if (req_i) begin
      if (hdr_i.len == ADDR_ONLY_LEN) begin
        d1_wr_o = 1'b1;
        if (!hdr_i.op[OP_MOT_BIT] || hdr_i.addr == 16'h0000) begin
          // stop, or restart toward address 0
          sel_n   = 1'b0;
          avail_n = 1'b0;
          ptr_n   = '0;
        end else if (hdr_i.addr == TARGET_ADDR) begin
          sel_n   = 1'b1;
          avail_n = avail_q | monitor_i;
        end
      end else if (!hdr_i.op[OP_READ_BIT]) begin
        d1_wr_o = 1'b1;
      end else if (hdr_i.len == READ_LEN) begin
        d1_wr_o = 1'b1;
        if (sel_q && avail_q) begin
          if (ptr_q < PTR_END) begin
            byte_c = tbl_byte_i;
            ptr_n  = ptr_q + PTR_W'(1);
          end
        end else begin
          byte_c = MISS_BYTE;
        end
      end
      d1_val_o = {ACK_CODE, byte_c, 16'h0000};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_n;
      sel_q   <= sel_n;
      avail_q <= avail_n;
    end
  end

  assign tbl_idx_o = ptr_q[IDX_W-1:0];

endmodule

// File: rtl/aux_reg_bank.sv
module aux_reg_bank
  import aux_edid_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          host_we_i,
  input  reg_sel_e                      host_sel_i,
  input  logic [DATA_W-1:0]             host_wdata_i,
  input  logic                          ctrl_we_i,
  input  logic [DATA_W-1:0]             ctrl_val_i,
  input  logic                          d1_we_i,
  input  logic [DATA_W-1:0]             d1_val_i,
  output logic [DATA_W-1:0]             ctrl_o,
  output logic [N_DATA-1:0][DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= '0;
    else if (ctrl_we_i) ctrl_o <= ctrl_val_i;
  end

  for (genvar k = 0; k < N_DATA; k++) begin : g_data
    logic host_hit;
    logic reply_hit;
    assign host_hit  = host_we_i && (host_sel_i == reg_sel_e'(3'(k + 1)));
    assign reply_hit = (k == 0) ? d1_we_i : 1'b0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        data_o[k] <= '0;
      else if (reply_hit) data_o[k] <= d1_val_i;
      else if (host_hit)  data_o[k] <= host_wdata_i;
    end
  end

endmodule

// File: rtl/aux_i2c_edid_resp.sv
module aux_i2c_edid_resp
  import aux_edid_pkg::*;
#(
  parameter int unsigned EDID_DEPTH  = 128,
  parameter logic [15:0] TARGET_ADDR = 16'h0050,
  localparam int unsigned IDX_W = $clog2(EDID_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [7:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              monitor_present_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [7:0]        tbl_data_i
);

  reg_sel_e                      wr_sel;
  logic                          ctrl_wr, req, host_data_we;
  logic [DATA_W-1:0]             ctrl_q, d1_q, ctrl_reply, d1_reply;
  logic [N_DATA-1:0][DATA_W-1:0] data_q;
  logic                          d1_reply_we;
  req_hdr_t                      hdr;
  logic [IDX_W-1:0]              tbl_idx;
  logic [7:0]                    tbl_byte;

  assign wr_sel       = decode_off(wr_addr_i);
  assign ctrl_wr      = wr_en_i && (wr_sel == SEL_CTRL);
  assign req          = ctrl_wr && wr_data_i[BUSY_BIT];
  assign host_data_we = wr_en_i && (wr_sel != SEL_CTRL) && (wr_sel != SEL_NONE);
  assign d1_q         = data_q[0];

  assign hdr.op   = d1_q[31:28];
  assign hdr.addr = d1_q[23:8];
  assign hdr.len  = wr_data_i[SIZE_LSB +: SIZE_W];

  always_comb begin
    ctrl_reply = '0;
    ctrl_reply[DONE_BIT] = 1'b1;
    ctrl_reply[SIZE_LSB +: SIZE_W] = hdr.op[OP_READ_BIT] ? RSZ_READ : RSZ_WRITE;
  end

  edid_table #(.DEPTH(EDID_DEPTH)) u_table (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (tbl_idx),
    .rdata_o (tbl_byte)
  );

  aux_i2c_session #(.DEPTH(EDID_DEPTH), .TARGET_ADDR(TARGET_ADDR)) u_session (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .hdr_i      (hdr),
    .monitor_i  (monitor_present_i),
    .tbl_byte_i (tbl_byte),
    .tbl_idx_o  (tbl_idx),
    .d1_wr_o    (d1_reply_we),
    .d1_val_o   (d1_reply)
  );

  aux_reg_bank u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_data_we),
    .host_sel_i   (wr_sel),
    .host_wdata_i (wr_data_i),
    .ctrl_we_i    (req),
    .ctrl_val_i   (ctrl_reply),
    .d1_we_i      (d1_reply_we),
    .d1_val_i     (d1_reply),
    .ctrl_o       (ctrl_q),
    .data_o       (data_q)
  );

  always_comb begin
    case (decode_off(rd_addr_i))
      SEL_CTRL: rd_data_o = ctrl_q;
      SEL_D1:   rd_data_o = data_q[0];
      SEL_D2:   rd_data_o = data_q[1];
      SEL_D3:   rd_data_o = data_q[2];
      SEL_D4:   rd_data_o = data_q[3];
      SEL_D5:   rd_data_o = data_q[4];
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/aux_edid_chk.sv
module aux_edid_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [7:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] ctrl_q,
  input logic [31:0] d1_q
);

  logic ctl_wr, busy_wr;
  logic [4:0] len;
  assign ctl_wr  = wr_en_i && (wr_addr_i == 8'h10);
  assign busy_wr = ctl_wr && wr_data_i[31];
  assign len     = wr_data_i[24:20];

  // R4
  reply_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_wr |=> (ctrl_q[31:30] == 2'b01) &&
                (ctrl_q[24:20] == ($past(d1_q[28]) ? 5'd2 : 5'd1)));

  // R3
  idle_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !wr_data_i[31]) |=> ($stable(ctrl_q) && $stable(d1_q)));

  // R2
  data1_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 8'h14) |=> (d1_q == $past(wr_data_i)));

  // R11
  write_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_wr && len != 5'd3 && !d1_q[28]) |=> (d1_q == 32'h0000_0000));

  // R8
  read_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_wr && len == 5'd4 && d1_q[28]) |=> (d1_q[31:24] == 8'h00 && d1_q[15:0] == 16'h0));

  // R12
  bad_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_wr && len != 5'd3 && len != 5'd4 && d1_q[28]) |=> $stable(d1_q));

endmodule

bind aux_i2c_edid_resp aux_edid_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ctrl_q    (ctrl_q),
  .d1_q      (d1_q)
);

// File: tb/aux_i2c_edid_resp_tb_top.sv
`timescale 1ns/1ps
module aux_i2c_edid_resp_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mon = 1'b0;
  logic        tbl_we = 1'b0;
  logic [6:0]  tbl_addr = '0;
  logic [7:0]  tbl_data = '0;

  int n_checks = 0;
  int n_errors = 0;

  // model state
  logic [31:0] m_ctrl;
  logic [31:0] m_d [5];
  logic        m_sel, m_avail;
  int          m_ptr;
  logic [7:0]  m_tbl [128];

  always #2.5 clk = ~clk;

  aux_i2c_edid_resp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .monitor_present_i(mon), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_data_i(tbl_data)
  );

  function automatic int reg_idx(input logic [7:0] a);
    case (a)
      8'h10: return 0;
      8'h14: return 1;
      8'h18: return 2;
      8'h1C: return 3;
      8'h20: return 4;
      8'h24: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] m_val(input logic [7:0] a);
    int i = reg_idx(a);
    if (i == 0) return m_ctrl;
    if (i > 0) return m_d[i-1];
    return 32'h0;
  endfunction

  task automatic m_reset_session();
    m_sel = 1'b0; m_avail = 1'b0; m_ptr = 0;
  endtask

  task automatic m_write(input logic [7:0] a, input logic [31:0] d);
    int i = reg_idx(a);
    logic [3:0] op; logic [15:0] ad; logic [4:0] len; logic [7:0] b;
    if (i > 0) begin m_d[i-1] = d; return; end
    if (i < 0 || !d[31]) return;
    op = m_d[0][31:28]; ad = m_d[0][23:8]; len = d[24:20];
    m_ctrl = 32'h4000_0000 | ({27'h0, op[0] ? 5'd2 : 5'd1} << 20);
    if (len == 5'd3) begin
      m_d[0] = 32'h0;
      if (!op[2] || ad == 16'h0) m_reset_session();
      else if (ad == 16'h0050) begin m_sel = 1'b1; m_avail = m_avail | mon; end
    end else if (!op[0]) m_d[0] = 32'h0;
    else if (len == 5'd4) begin
      if (m_sel && m_avail) begin
        if (m_ptr < 128) begin b = m_tbl[m_ptr]; m_ptr++; end
        else b = 8'h00;
      end else b = 8'hFF;
      m_d[0] = {8'h00, b, 16'h0};
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(a, d);
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #0.2;
    n_checks++;
    if (rd_data !== exp) begin
      n_errors++;
      $display("FAIL %s off=%02h actual=%08h expected=%08h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(8'h10, m_val(8'h10), req);
    chk(8'h14, m_val(8'h14), req);
    chk(8'h18, m_val(8'h18), req);
    chk(8'h1C, m_val(8'h1C), req);
    chk(8'h20, m_val(8'h20), req);
    chk(8'h24, m_val(8'h24), req);
  endtask

  // issue a request: header into data 1, then busy control write with length
  task automatic xfer(input logic [31:0] hdr, input logic [4:0] len);
    wr(8'h14, hdr);
    wr(8'h10, 32'h8000_0000 | ({27'h0, len} << 20));
  endtask

  initial begin
    #500000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] hdr_rd_sel, hdr_rd;
    m_ctrl = '0;
    for (int i = 0; i < 5; i++) m_d[i] = '0;
    m_reset_session();
    void'($urandom(32'd20240611));
    hdr_rd_sel = 32'h5000_5000;  // read, MOT, address 0x50
    hdr_rd     = 32'h1000_0000;  // read, no MOT

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1");
    chk(8'h28, 32'h0, "R2");

    // R13 load table
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 7'(i); tbl_data = 8'((i * 37 + 11) ^ (i >> 3));
      m_tbl[i] = 8'((i * 37 + 11) ^ (i >> 3));
    end
    @(negedge clk); tbl_we = 1'b0;

    // R9 / R1: read before selection
    xfer(hdr_rd, 5'd4);
    chk(8'h14, 32'h00FF_0000, "R9");
    chk(8'h10, 32'h4020_0000, "R4");

    // R2 data storage and stray offset
    wr(8'h18, 32'hA5A5_0001); wr(8'h1C, 32'h1234_5678);
    wr(8'h20, 32'hDEAD_BEEF); wr(8'h24, 32'h0F0F_F0F0);
    wr(8'h30, 32'hFFFF_FFFF);
    chk_all("R2");
    chk(8'h30, 32'h0, "R2");

    // R3 non-busy control write
    wr(8'h10, 32'h7FFF_FFFF);
    chk_all("R3");

    // R7 select with monitor, R8 reads walk the table
    mon = 1'b1;
    xfer(hdr_rd_sel, 5'd3);
    chk(8'h14, 32'h0, "R7");
    chk(8'h10, 32'h4020_0000, "R4");
    for (int i = 0; i < 3; i++) begin
      xfer(hdr_rd_sel, 5'd4);
      chk(8'h14, {8'h00, m_tbl[i], 16'h0}, "R8");
    end

    // R11 write request ignored, next read continues at byte 3
    xfer(32'h4000_5000, 5'd4);
    chk(8'h14, 32'h0, "R11");
    chk(8'h10, 32'h4010_0000, "R4");
    xfer(hdr_rd_sel, 5'd4);
    chk(8'h14, {8'h00, m_tbl[3], 16'h0}, "R11");

    // R12 read with length 5 leaves data 1
    xfer(hdr_rd_sel, 5'd5);
    chk(8'h14, hdr_rd_sel, "R12");
    chk(8'h10, 32'h4020_0000, "R12");

    // R10 read to the end and beyond
    for (int i = 4; i < 128; i++) begin
      xfer(hdr_rd_sel, 5'd4);
      chk(8'h14, {8'h00, m_tbl[i], 16'h0}, "R8");
    end
    xfer(hdr_rd_sel, 5'd4);
    chk(8'h14, 32'h0, "R10");
    xfer(hdr_rd_sel, 5'd4);
    chk(8'h14, 32'h0, "R10");

    // R6 stop then read gives miss byte
    xfer(32'h1000_5000, 5'd3);
    xfer(hdr_rd, 5'd4);
    chk(8'h14, 32'h00FF_0000, "R6");

    // R7 restart at address 0 resets, pointer back to byte 0 after reselect
    xfer(hdr_rd_sel, 5'd3);
    xfer(hdr_rd_sel, 5'd4);
    chk(8'h14, {8'h00, m_tbl[0], 16'h0}, "R6");
    xfer(32'h5000_0000, 5'd3);
    xfer(hdr_rd_sel, 5'd4);
    chk(8'h14, 32'h00FF_0000, "R7");

    // R7 select without monitor
    mon = 1'b0;
    xfer(hdr_rd_sel, 5'd3);
    xfer(hdr_rd_sel, 5'd4);
    chk(8'h14, 32'h00FF_0000, "R7");

    // R5 random headers, lengths and data writes against the model
    for (int it = 0; it < 400; it++) begin
      int kind = $urandom_range(0, 9);
      logic [3:0]  op = 4'($urandom);
      logic [15:0] ad;
      logic [4:0]  len;
      case ($urandom_range(0, 3))
        0: ad = 16'h0000;
        1, 2: ad = 16'h0050;
        default: ad = 16'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: len = 5'd3;
        1, 2: len = 5'd4;
        default: len = 5'($urandom);
      endcase
      mon = ($urandom_range(0, 3) != 0);
      if (kind < 6) xfer({op, 4'($urandom), ad, 8'($urandom)}, len);
      else if (kind == 6) wr(8'h10, {1'b0, 31'($urandom)});
      else if (kind == 7) wr(8'($urandom), $urandom);
      else wr(8'h18 + 8'(4 * $urandom_range(0, 3)), $urandom);
      chk_all("R5");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule